// File: doc/BRIEF.md
# Mode-Dependent Pixel Clock Generator

This block divides the system clock by a programmable integer to produce a display pixel clock. The pixel clock is a registered output, so every transition happens on a system clock edge. Two one-cycle strobes, synchronous to the system clock, mark each rising and each falling pixel-clock transition. Downstream timing logic can use them as clock enables and never has to sample the divided clock.

There are two operating modes. In free-running mode (`mode_passive` = 0) the clock toggles for as long as `en` is high, and the three qualifier inputs are ignored. In gated mode (`mode_passive` = 1) a new pixel period may start only while the raster logic reports valid data and neither a line-sync pulse nor a wait state is active. When a qualifier blocks output, the clock settles low and stays there. It restarts with a complete high phase once output is permitted again.

A divider value below 2 is not a legal setting. The block runs such a value as 2 and sets a sticky error flag. The block has no data stream, so every pin is a plain level-sensitive control or status signal with no handshake or back-pressure.

Top module: `pclk_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `pclk`, `rise_stb`, `fall_stb` and `div_err` are all 0.
- R2: With an effective divider N (N >= 2), running without interruption, `pclk` stays high for floor(N/2) system cycles and then low for N - floor(N/2) cycles, giving a period of exactly N cycles.
- R3: On the first clock edge at which `en` is sampled high and output is permitted, `pclk` goes high, and that first high phase has the full length floor(N/2).
- R4: A `div_val` of 0 or 1 produces the same waveform as a `div_val` of 2.
- R5: `div_err` becomes 1 on the clock edge at which `en` is high and `div_val` < 2. It then stays 1 until reset, even after a legal value is loaded. It stays 0 as long as only legal values are used.
- R6: With `mode_passive` = 0, the inputs `data_valid`, `line_sync` and `wait_st` have no effect on `pclk`.
- R7: With `mode_passive` = 1, on any edge where `data_valid` is 0, `line_sync` is 1 or `wait_st` is 1, `pclk` does not rise. If it is low, it holds low.
- R8: If gating begins while `pclk` is high, the high phase already started runs to its full floor(N/2) cycles, then `pclk` falls and holds low.
- R9: When gating lifts after `pclk` has settled low, `pclk` rises on the first permitted edge and starts a fresh full period.
- R10: When `en` is sampled low, `pclk` is 0 after that edge and the phase count is cleared, so a later enable starts as in R3.
- R11: `rise_stb` is 1 exactly in the cycles where `pclk` is 1 and was 0 in the previous cycle. `fall_stb` is 1 exactly in the cycles where `pclk` is 0 and was 1. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables the pixel clock; low forces it low and clears the phase count |
| div_val | input | DIV_W | Divider N; 0 and 1 are illegal and run as 2 |
| mode_passive | input | 1 | 1 selects gated mode, 0 selects free-running mode |
| data_valid | input | 1 | Pixel data is being presented (gated mode only) |
| line_sync | input | 1 | Line-sync pulse is active (gated mode only) |
| wait_st | input | 1 | A wait state is inserted (gated mode only) |
| pclk | output | 1 | Registered pixel clock |
| rise_stb | output | 1 | One-cycle strobe in the cycle `pclk` becomes high |
| fall_stb | output | 1 | One-cycle strobe in the cycle `pclk` becomes low |
| div_err | output | 1 | Sticky flag: an illegal divider was used while enabled |

## Verification
The bench compares `pclk` and both strobes against an expected trace every cycle, using even and odd dividers and the illegal values 0 and 1. An off-by-one phase counter would stretch or shorten the period, and a wrong split would give odd dividers the longer phase high instead of low. Gating is applied just after a rising edge, at a larger divider, and while the clock is already low. A design that chopped the high phase short, let a rise slip through during line sync or wait states, or restarted mid-period instead of with a fresh high phase would drift from the trace within a cycle or two. Toggling the qualifiers in free-running mode exposes a gate that ignores the mode select, and a legal divider loaded after an illegal one exposes an error flag that is not sticky.

// File: rtl/pclk_pkg.sv
`timescale 1ns/1ps
package pclk_pkg;

  // Per-cycle action chosen by the qualifier logic.
  typedef enum logic [1:0] {
    STEP_OFF  = 2'd0,  // block disabled: force low, clear count
    STEP_RUN  = 2'd1,  // output permitted: advance the phase
    STEP_GATE = 2'd2   // output blocked: drain a high phase, hold low
  } pclk_step_e;

  // Smallest divider that raster operation accepts.
  localparam int unsigned PCLK_MIN_DIV = 2;

endpackage

// File: rtl/pclk_div_legal.sv
`timescale 1ns/1ps
module pclk_div_legal #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_raw,
  output logic [DIV_W-1:0] hi_len,
  output logic [DIV_W-1:0] lo_len,
  output logic             err_sticky
);
  import pclk_pkg::*;

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(PCLK_MIN_DIV);

  logic             illegal;
  logic [DIV_W-1:0] eff_div;
  logic             err_q;

  // Values under the minimum run as the minimum.
  assign illegal = (div_raw < MIN_DIV);
  assign eff_div = illegal ? MIN_DIV : div_raw;

  // The high phase takes the floor half; the low phase takes the rest.
  assign hi_len = eff_div >> 1;
  assign lo_len = eff_div - hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (en && illegal) begin
      err_q <= 1'b1;
    end
  end

  assign err_sticky = err_q;

  // R5: once raised, the flag holds until reset
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R5: an illegal value used while enabled raises the flag
  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (div_raw < MIN_DIV)) |=> err_sticky);

endmodule

// File: rtl/pclk_gate_qual.sv
`timescale 1ns/1ps
module pclk_gate_qual (
  input  logic                 en,
  input  logic                 mode_passive,
  input  logic                 data_valid,
  input  logic                 line_sync,
  input  logic                 wait_st,
  output pclk_pkg::pclk_step_e step
);
  import pclk_pkg::*;

  logic permit;

  // Gated mode allows output only while data is valid and no sync or wait runs.
  assign permit = !mode_passive || (data_valid && !line_sync && !wait_st);

  always_comb begin
    if (!en) begin
      step = STEP_OFF;
    end else if (permit) begin
      step = STEP_RUN;
    end else begin
      step = STEP_GATE;
    end
  end

endmodule

// File: rtl/pclk_phase_gen.sv
`timescale 1ns/1ps
module pclk_phase_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pclk_pkg::pclk_step_e step,
  input  logic [DIV_W-1:0]     hi_len,
  input  logic [DIV_W-1:0]     lo_len,
  output logic                 pclk,
  output logic                 rise_stb,
  output logic                 fall_stb
);
  import pclk_pkg::*;

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic             pclk_q, pclk_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             fresh_q, fresh_d;   // next permitted edge starts a new period
  logic             rise_q, fall_q;
  logic             hi_done, lo_done;

  assign hi_done = (cnt_q >= hi_len - ONE);
  assign lo_done = (cnt_q >= lo_len - ONE);

  always_comb begin
    pclk_d  = pclk_q;
    cnt_d   = cnt_q;
    fresh_d = fresh_q;
    unique case (step)
      STEP_RUN: begin
        if (fresh_q || (!pclk_q && lo_done)) begin
          pclk_d  = 1'b1;
          cnt_d   = '0;
          fresh_d = 1'b0;
        end else if (pclk_q && hi_done) begin
          pclk_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      STEP_GATE: begin
        if (pclk_q && !hi_done) begin
          cnt_d = cnt_q + ONE;      // let the started high phase finish
        end else begin
          pclk_d  = 1'b0;
          cnt_d   = '0;
          fresh_d = 1'b1;
        end
      end
      default: begin              // STEP_OFF
        pclk_d  = 1'b0;
        cnt_d   = '0;
        fresh_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q  <= 1'b0;
      cnt_q   <= '0;
      fresh_q <= 1'b1;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      pclk_q  <= pclk_d;
      cnt_q   <= cnt_d;
      fresh_q <= fresh_d;
      rise_q  <= pclk_d && !pclk_q;
      fall_q  <= !pclk_d && pclk_q;
    end
  end

  assign pclk     = pclk_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;

  // R10: a disabled cycle leaves the clock low
  p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_OFF) |=> !pclk);

  // R7: no rising edge while gated
  p_no_rise_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_GATE) |=> !rise_stb);

  // R7: a low clock stays low under gating
  p_hold_low_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((step == STEP_GATE) && !pclk) |=> !pclk);

  // R11: strobes never coincide
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  // R11: a rise strobe marks a low-to-high change
  p_rise_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pclk ##1 pclk |-> rise_stb);

  // R11: a fall strobe marks a high-to-low change
  p_fall_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pclk ##1 !pclk |-> fall_stb);

endmodule

// File: rtl/pclk_gen.sv
`timescale 1ns/1ps
module pclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             mode_passive,
  input  logic             data_valid,
  input  logic             line_sync,
  input  logic             wait_st,
  output logic             pclk,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             div_err
);
  import pclk_pkg::*;

  logic [DIV_W-1:0] hi_len;
  logic [DIV_W-1:0] lo_len;
  pclk_step_e       step;

  pclk_div_legal #(.DIV_W(DIV_W)) u_legal (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .div_raw    (div_val),
    .hi_len     (hi_len),
    .lo_len     (lo_len),
    .err_sticky (div_err)
  );

  pclk_gate_qual u_qual (
    .en           (en),
    .mode_passive (mode_passive),
    .data_valid   (data_valid),
    .line_sync    (line_sync),
    .wait_st      (wait_st),
    .step         (step)
  );

  pclk_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .hi_len   (hi_len),
    .lo_len   (lo_len),
    .pclk     (pclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  // R6: free-running mode never gates, so an enabled cycle never leaves
  // a low clock low for longer than the low phase allows (strobe sanity)
  p_run_not_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode_passive) |-> (step == STEP_RUN));

endmodule

// File: tb/sim_pclk_gen.sv
`timescale 1ns/1ps
module sim_pclk_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  typedef struct {
    logic  p;
    logic  r;
    logic  f;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [DW-1:0] div_val = '0;
  logic          mode_passive = 1'b0;
  logic          data_valid = 1'b0;
  logic          line_sync = 1'b0;
  logic          wait_st = 1'b0;
  logic          pclk, rise_stb, fall_stb, div_err;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  // expected-trace state
  logic m_p = 1'b0;
  logic m_fresh = 1'b1;
  int   m_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_gen #(.DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val),
    .mode_passive(mode_passive), .data_valid(data_valid),
    .line_sync(line_sync), .wait_st(wait_st),
    .pclk(pclk), .rise_stb(rise_stb), .fall_stb(fall_stb), .div_err(div_err)
  );

  task automatic check1(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of inputs and push the expected outputs.
  task automatic drive(input logic e, input int d, input logic m,
                       input logic dv, input logic ls, input logic ws, input string req);
    int n, hi;
    logic run, p;
    exp_t it;
    @(negedge clk);
    en = e; div_val = DW'(d); mode_passive = m;
    data_valid = dv; line_sync = ls; wait_st = ws;
    n   = (d < 2) ? 2 : d;
    hi  = n / 2;
    run = e && (!m || (dv && !ls && !ws));
    if (!e) begin
      p = 1'b0; m_fresh = 1'b1; m_idx = 0;
    end else if (run) begin
      if (m_fresh) begin
        m_idx = 0; m_fresh = 1'b0;
      end else begin
        m_idx++;
        if (m_idx >= n) m_idx = 0;
      end
      p = (m_idx < hi);
    end else begin
      if (m_p && (m_idx + 1 < hi)) begin
        m_idx++; p = 1'b1;
      end else begin
        p = 1'b0; m_fresh = 1'b1; m_idx = 0;
      end
    end
    it.p = p; it.r = p && !m_p; it.f = !p && m_p; it.req = req;
    m_p = p;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare outputs after each edge against the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check1(pclk, it.p, it.req, "pclk");
        check1(rise_stb, it.r, "R11", "rise_stb");
        check1(fall_stb, it.f, "R11", "fall_stb");
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check1(pclk, 1'b0, "R1", "pclk in reset");
    check1(div_err, 1'b0, "R1", "div_err in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check1(pclk, 1'b0, "R1", "pclk after reset");
    check1(rise_stb, 1'b0, "R1", "rise_stb after reset");
    check1(fall_stb, 1'b0, "R1", "fall_stb after reset");

    // R2, R3: free-running even divider; disable mid high phase (R10)
    for (int k = 0; k < 14; k++) drive(1, 4, 0, 1, 0, 0, "R2");
    for (int k = 0; k < 2; k++)  drive(0, 4, 0, 1, 0, 0, "R10");
    for (int k = 0; k < 3; k++)  drive(1, 4, 0, 1, 0, 0, "R3");
    drive(0, 4, 0, 0, 0, 0, "R10");

    // R2, R6: odd divider with qualifiers toggling in free-running mode
    for (int k = 0; k < 15; k++) drive(1, 5, 0, k[0], k[1], k[2], "R6");
    drive(0, 5, 0, 0, 0, 0, "R10");
    for (int k = 0; k < 9; k++) drive(1, 3, 0, 1, 0, 0, "R2");
    drive(0, 3, 0, 0, 0, 0, "R10");
    drain();
    check1(div_err, 1'b0, "R5", "div_err after legal values");

    // R4, R5: illegal dividers
    for (int k = 0; k < 8; k++) drive(1, 0, 0, 1, 0, 0, "R4");
    drive(0, 0, 0, 0, 0, 0, "R10");
    drain();
    check1(div_err, 1'b1, "R5", "div_err after div 0");
    for (int k = 0; k < 6; k++) drive(1, 1, 0, 1, 0, 0, "R4");
    drive(0, 6, 0, 0, 0, 0, "R10");
    for (int k = 0; k < 12; k++) drive(1, 6, 0, 1, 0, 0, "R2");
    drive(0, 6, 0, 0, 0, 0, "R10");
    drain();
    check1(div_err, 1'b1, "R5", "div_err sticky after legal value");

    // R7, R8, R9: gated mode, divider 4
    for (int k = 0; k < 5; k++) drive(1, 4, 1, 1, 0, 0, "R9");
    for (int k = 0; k < 4; k++) drive(1, 4, 1, 1, 1, 0, "R8");
    for (int k = 0; k < 6; k++) drive(1, 4, 1, 1, 0, 0, "R9");
    for (int k = 0; k < 3; k++) drive(1, 4, 1, 1, 0, 1, "R7");
    for (int k = 0; k < 3; k++) drive(1, 4, 1, 0, 0, 0, "R7");
    for (int k = 0; k < 4; k++) drive(1, 4, 1, 1, 0, 0, "R9");
    drive(0, 4, 1, 0, 0, 0, "R10");

    // R8: larger divider, gate shortly after a rise
    for (int k = 0; k < 2; k++)  drive(1, 8, 1, 1, 0, 0, "R3");
    for (int k = 0; k < 5; k++)  drive(1, 8, 1, 0, 0, 0, "R8");
    for (int k = 0; k < 10; k++) drive(1, 8, 1, 1, 0, 0, "R9");
    for (int k = 0; k < 3; k++)  drive(1, 8, 1, 1, 1, 1, "R7");
    drive(0, 8, 1, 0, 0, 0, "R10");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule